// File: doc/BRIEF.md
# Mailbox Interrupt Request Masking

This block turns per-register mailbox events into the two interrupt requests a processor sees from a host-facing mailbox: a host-write request and a host-read request. Each of the mailbox data registers contributes two events. A write event is latched when the host finishes writing the register, and it stays pending until the processor reads that register. A read-ready level is high while the outgoing side of the register is empty. It is high from reset, it falls when the processor places new outgoing data, and it rises again once the host has read that data.

Every event passes two gates. The first is a per-register enable held in a mask register that the processor reads and writes on its bus. The second is a global class enable for reads or for writes, which is supplied from outside the block. The gated write events are ORed into a single write request, and the gated read events into a single read request. Masking hides an event but does not discard it, so a pending event appears as soon as both of its gates open. The mask register comes out of reset with every register masked.

Top module: `mbox_irq_mask`

## Requirements
- R1: `wrIrq` is 1 exactly when `globalWrEn` is 1 and, for some register i, its write event is pending and mask bit i (bits 0 to NUM_REGS-1 are the write enables) is 1.
- R2: `rdIrq` is 1 exactly when `globalRdEn` is 1 and, for some register i, it is read-ready and mask bit NUM_REGS+i (bits NUM_REGS to 2*NUM_REGS-1 are the read enables) is 1.
- R3: A pulse on `hostWrDone[i]` makes register i's write event pending from the next clock edge on. If `procRdIn[i]` is high in the same cycle, the event is still pending afterwards.
- R4: A pulse on `procRdIn[i]` without `hostWrDone[i]` clears register i's pending write event at the next clock edge.
- R5: After reset every register is read-ready. A pulse on `procWrOut[i]` clears register i's read-ready at the next edge, and a pulse on `hostRdDone[i]` alone sets it. When both are high in one cycle, read-ready is cleared.
- R6: Reset clears all mask bits, so both requests are 0 after reset even with both global enables at 1.
- R7: A bus write with `busWrEn` at address `MASK_ADDR` (default 0x3FE8) loads `busWrData` into the mask at the next edge. A write to any other address leaves the mask unchanged. `busRdData` shows the mask when `busRdEn` is 1 at `MASK_ADDR`, and 0 otherwise.
- R8: Clearing a mask bit or a global enable does not discard a pending write event or a read-ready level. The request appears once both gates are open again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrDone | input | NUM_REGS | Per-register pulse: host completed a write |
| hostRdDone | input | NUM_REGS | Per-register pulse: host read the outgoing value |
| procWrOut | input | NUM_REGS | Per-register pulse: processor wrote new outgoing data |
| procRdIn | input | NUM_REGS | Per-register pulse: processor read the incoming data |
| globalRdEn | input | 1 | Global enable for the read request class |
| globalWrEn | input | 1 | Global enable for the write request class |
| busAddr | input | ADDR_W | Processor bus address |
| busWrEn | input | 1 | Processor bus write strobe |
| busWrData | input | 2*NUM_REGS | Processor bus write data (mask field) |
| busRdEn | input | 1 | Processor bus read strobe |
| busRdData | output | 2*NUM_REGS | Processor bus read data (mask field) |
| rdIrq | output | 1 | Combined host-read interrupt request |
| wrIrq | output | 1 | Combined host-write interrupt request |

## Verification
The write request is driven by events on one register while only another register's enable is set, and then by moving the enable onto it. This separates per-register gating from a plain OR of the events, and it shows whether masking throws away a pending event. The read request is first checked straight out of reset and then across processor writes and host reads, including a processor write and a host read in the same cycle. The write side is also driven with a host write and a processor read in the same cycle, so that the two opposite tie-break priorities are each checked. The global enables are toggled while events are pending to tell the class gate apart from the per-register gate. Bus accesses at the mask address and at a neighbouring address check the address decode for both reads and writes.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
  // Strobes the bus decode hands to the datapath.
  typedef struct packed {
    logic maskWe;  // load the mask register this cycle
    logic maskRe;  // drive the mask onto the read data
  } busStrobeT;
endpackage

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_irq_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 14'h3FE8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output busStrobeT         strobes
);
  logic addrHit;

  // R7: only the mask address selects the register
  always_comb begin
    addrHit = (busAddr == MASK_ADDR);
    strobes.maskWe = busWrEn && addrHit;
    strobes.maskRe = busRdEn && addrHit;
  end
endmodule

// File: rtl/mbox_irq_dp.sv
module mbox_irq_dp
  import mbox_irq_pkg::*;
#(
  parameter int NUM_REGS = 3,
  localparam int MASK_W = 2 * NUM_REGS
) (
  input  logic                clk,
  input  logic                rstN,
  input  busStrobeT           strobes,
  input  logic [MASK_W-1:0]   busWrData,
  output logic [MASK_W-1:0]   busRdData,
  input  logic [NUM_REGS-1:0] hostWrDone,
  input  logic [NUM_REGS-1:0] hostRdDone,
  input  logic [NUM_REGS-1:0] procWrOut,
  input  logic [NUM_REGS-1:0] procRdIn,
  input  logic                globalRdEn,
  input  logic                globalWrEn,
  output logic                rdIrq,
  output logic                wrIrq
);
  logic [MASK_W-1:0]   maskReg;
  logic [NUM_REGS-1:0] wrPend;
  logic [NUM_REGS-1:0] rdReady;
  logic [NUM_REGS-1:0] wrEnMask;
  logic [NUM_REGS-1:0] rdEnMask;

  // R6, R7: mask register, fully masked out of reset
  always_ff @(posedge clk) begin
    if (!rstN)                maskReg <= '0;
    else if (strobes.maskWe)  maskReg <= busWrData;
  end

  assign wrEnMask  = maskReg[NUM_REGS-1:0];
  assign rdEnMask  = maskReg[MASK_W-1:NUM_REGS];
  assign busRdData = strobes.maskRe ? maskReg : '0;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    // R3, R4: latched write event, a new host write wins a tie
    always_ff @(posedge clk) begin
      if (!rstN)              wrPend[i] <= 1'b0;
      else if (hostWrDone[i]) wrPend[i] <= 1'b1;
      else if (procRdIn[i])   wrPend[i] <= 1'b0;
    end

    // R5: outgoing side empty; new processor data wins a tie
    always_ff @(posedge clk) begin
      if (!rstN)              rdReady[i] <= 1'b1;
      else if (procWrOut[i])  rdReady[i] <= 1'b0;
      else if (hostRdDone[i]) rdReady[i] <= 1'b1;
    end

    p_wr_set_r3: assert property (@(posedge clk) disable iff (!rstN)
      hostWrDone[i] |=> wrPend[i]);
    p_wr_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
      (procRdIn[i] && !hostWrDone[i]) |=> !wrPend[i]);
    p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      procWrOut[i] |=> !rdReady[i]);
    p_rd_set_r5: assert property (@(posedge clk) disable iff (!rstN)
      (hostRdDone[i] && !procWrOut[i]) |=> rdReady[i]);
    // R8: masking never changes the event state
    p_wr_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
      (wrPend[i] && !procRdIn[i]) |=> wrPend[i]);
  end

  // R1, R2: two-level gating and OR reduction
  assign wrIrq = globalWrEn && |(wrPend & wrEnMask);
  assign rdIrq = globalRdEn && |(rdReady & rdEnMask);

  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.maskWe |=> $stable(maskReg));
  p_mask_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskWe |=> (maskReg == $past(busWrData)));
  p_wr_class_r1: assert property (@(posedge clk) disable iff (!rstN)
    wrIrq |-> (globalWrEn && wrPend != '0));
  p_rd_class_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdIrq |-> (globalRdEn && rdReady != '0));
endmodule

// File: rtl/mbox_irq_mask.sv
module mbox_irq_mask
  import mbox_irq_pkg::*;
#(
  parameter int NUM_REGS = 3,
  parameter int ADDR_W = 14,
  parameter logic [ADDR_W-1:0] MASK_ADDR = 14'h3FE8,
  localparam int MASK_W = 2 * NUM_REGS
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_REGS-1:0] hostWrDone,
  input  logic [NUM_REGS-1:0] hostRdDone,
  input  logic [NUM_REGS-1:0] procWrOut,
  input  logic [NUM_REGS-1:0] procRdIn,
  input  logic                globalRdEn,
  input  logic                globalWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrEn,
  input  logic [MASK_W-1:0]   busWrData,
  input  logic                busRdEn,
  output logic [MASK_W-1:0]   busRdData,
  output logic                rdIrq,
  output logic                wrIrq
);
  busStrobeT strobes;

  mbox_irq_ctrl #(.ADDR_W(ADDR_W), .MASK_ADDR(MASK_ADDR)) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .strobes (strobes)
  );

  mbox_irq_dp #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .hostWrDone (hostWrDone),
    .hostRdDone (hostRdDone),
    .procWrOut  (procWrOut),
    .procRdIn   (procRdIn),
    .globalRdEn (globalRdEn),
    .globalWrEn (globalWrEn),
    .rdIrq      (rdIrq),
    .wrIrq      (wrIrq)
  );
endmodule

// File: tb/mbox_irq_mask_test.sv
module mbox_irq_mask_test;
  localparam int N = 3;
  localparam int AW = 14;
  localparam logic [AW-1:0] MADDR = 14'h3FE8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] hostWrDone = '0, hostRdDone = '0, procWrOut = '0, procRdIn = '0;
  logic globalRdEn = 1'b1, globalWrEn = 1'b1;
  logic [AW-1:0] busAddr = MADDR;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2*N-1:0] busWrData = '0;
  logic [2*N-1:0] busRdData;
  logic rdIrq, wrIrq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  mbox_irq_mask uut (
    .clk(clk), .rstN(rstN), .hostWrDone(hostWrDone), .hostRdDone(hostRdDone),
    .procWrOut(procWrOut), .procRdIn(procRdIn), .globalRdEn(globalRdEn),
    .globalWrEn(globalWrEn), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .rdIrq(rdIrq), .wrIrq(wrIrq)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic writeMask(input logic [AW-1:0] addr, input logic [2*N-1:0] val);
    busAddr = addr; busWrData = val; busWrEn = 1'b1;
    step();
    busWrEn = 1'b0; busAddr = MADDR;
  endtask

  task automatic readMask(input logic [AW-1:0] addr, input logic en, output int val);
    busAddr = addr; busRdEn = en;
    #1 val = int'(busRdData);
    busRdEn = 1'b0; busAddr = MADDR;
  endtask

  task automatic pulse(input logic [N-1:0] hw, input logic [N-1:0] hr,
                       input logic [N-1:0] pw, input logic [N-1:0] pr);
    hostWrDone = hw; hostRdDone = hr; procWrOut = pw; procRdIn = pr;
    step();
    hostWrDone = '0; hostRdDone = '0; procWrOut = '0; procRdIn = '0;
  endtask

  task automatic testReset();
    int v;
    check("R6 rdIrq after reset", rdIrq, 0);
    check("R6 wrIrq after reset", wrIrq, 0);
    readMask(MADDR, 1'b1, v);
    check("R6 mask after reset", v, 0);
  endtask

  task automatic testReadReady();
    writeMask(MADDR, 6'h38);
    check("R2 R5 read-ready from reset", rdIrq, 1);
    globalRdEn = 1'b0; #1;
    check("R2 global read enable off", rdIrq, 0);
    globalRdEn = 1'b1; #1;
    pulse(3'b000, 3'b000, 3'b111, 3'b000);
    check("R5 processor writes clear ready", rdIrq, 0);
    pulse(3'b000, 3'b010, 3'b000, 3'b000);
    check("R5 host read sets ready", rdIrq, 1);
    writeMask(MADDR, 6'h28);
    check("R2 per-register read mask", rdIrq, 0);
    writeMask(MADDR, 6'h10);
    check("R8 read-ready kept while masked", rdIrq, 1);
    pulse(3'b000, 3'b001, 3'b001, 3'b000);
    writeMask(MADDR, 6'h08);
    check("R5 tie leaves ready cleared", rdIrq, 0);
    pulse(3'b000, 3'b001, 3'b000, 3'b000);
    check("R5 host read on reg0", rdIrq, 1);
  endtask

  task automatic testWrite();
    writeMask(MADDR, 6'h01);
    check("R1 no write events yet", wrIrq, 0);
    pulse(3'b100, 3'b000, 3'b000, 3'b000);
    check("R1 masked reg2 event", wrIrq, 0);
    writeMask(MADDR, 6'h04);
    check("R8 pending shows once unmasked", wrIrq, 1);
    pulse(3'b000, 3'b000, 3'b000, 3'b100);
    check("R4 processor read clears pending", wrIrq, 0);
    pulse(3'b001, 3'b000, 3'b000, 3'b000);
    check("R1 reg0 event masked", wrIrq, 0);
    pulse(3'b001, 3'b000, 3'b000, 3'b001);
    writeMask(MADDR, 6'h01);
    check("R3 tie keeps pending", wrIrq, 1);
    globalWrEn = 1'b0; #1;
    check("R1 global write enable off", wrIrq, 0);
    globalWrEn = 1'b1; #1;
    check("R8 pending kept across global disable", wrIrq, 1);
    pulse(3'b000, 3'b000, 3'b000, 3'b001);
    check("R4 reg0 cleared", wrIrq, 0);
  endtask

  task automatic testDecode();
    int v;
    writeMask(MADDR, 6'h2A);
    readMask(MADDR, 1'b1, v);
    check("R7 readback", v, 'h2A);
    writeMask(MADDR + 14'd1, 6'h00);
    readMask(MADDR, 1'b1, v);
    check("R7 write to other address ignored", v, 'h2A);
    readMask(MADDR + 14'd1, 1'b1, v);
    check("R7 read at other address", v, 0);
    readMask(MADDR, 1'b0, v);
    check("R7 read without strobe", v, 0);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    testReset();
    testReadReady();
    testWrite();
    testDecode();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule